// File: doc/BRIEF.md
# Serial Video Bit Decoder and Word Aligner

This block sits behind a clock-data-recovery front end and receives one recovered bit per clock. The bits first pass an NRZI-to-NRZ converter and then a self-synchronizing descrambler. A framer then looks at the last thirty decoded bits for a timing reference sequence and uses it to fix the ten-bit word boundary. Words are put together least significant bit first. They leave the block with a one-cycle strobe, a flag that marks the first timing reference word, and a flag that tells whether any timing reference has been seen since reset.

An eight-bit control register holds four independent enables: NRZI decoding, descrambling, timing reference detection and clipping of the two low bits of timing reference words. The register resets to 36h, which turns all four on. A write port loads a new value. The bits that are not listed are reserved, are stored, and have no effect.

The framer is a two-state machine. FR_HUNT is entered at reset: words come out on a free-running boundary that starts at reset, and they are marked unaligned. The transition FR_HUNT to FR_LOCK happens on the first timing reference match while detection is enabled. In FR_LOCK the machine takes its only transition back to FR_LOCK: each later match realigns the boundary again. Only reset leaves FR_LOCK.

Top module: `sdi_descrambler_aligner`

## Requirements
- R1: The control register `ctrl_q` reads 36h after reset. While `cfg_we` is high, `cfg_wdata` is loaded on the clock edge and is visible in the next cycle.
- R2: When control bit 2 is set, each decoded bit is the XOR of the current and previous line bits (polynomial x+1). When bit 2 is clear, line bits pass through unchanged.
- R3: When control bit 1 is set, each output bit is the descrambler input XOR that input delayed by 4 bits XOR that input delayed by 9 bits (x^9+x^4+1). When bit 1 is clear, the stage passes its input through.
- R4: A timing reference is the word sequence 3FFh, 000h, 000h, each word received LSB first. It is matched on the bit where its last bit arrives. The strobe for 3FFh comes with `trs_found` high. Strobes carrying 000h and 000h follow 10 and 20 clocks later, and the payload words follow from then on, in order.
- R5: When control bit 5 is clear, no timing reference is matched: `trs_found` stays low and the word boundary does not move.
- R6: When control bit 4 is set, bits [1:0] of all three timing reference words are output as 00b, so the first word reads 3FCh. When bit 4 is clear, it reads 3FFh.
- R7: `word_stb` is a single-cycle pulse. Outside a realignment it comes exactly ten clocks after the previous strobe.
- R8: `word_aligned` is low from reset until the first match and stays high after it until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Recovered line bit |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register contents |
| word_out | output | 10 | Assembled word |
| word_stb | output | 1 | Word valid strobe |
| trs_found | output | 1 | First timing reference word on this strobe |
| word_aligned | output | 1 | Boundary fixed by a timing reference |

## Verification
The bench builds the block with its default parameters: ten-bit words, descrambler taps at 4 and 9, and two clipped bits. These values give a thirty-bit match window, so a timing reference can be started at any bit offset from the reset boundary. A second reference arriving seven bits off the current boundary exercises the move from FR_LOCK back to FR_LOCK. The bench scrambles and NRZI-encodes its own words under the same enable bits, so each bypass combination is checked end to end through the real decoders.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
    localparam int CTRL_W = 8;
    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h36;
    // control bit positions
    localparam int CB_DSCR = 1;
    localparam int CB_NRZI = 2;
    localparam int CB_CLIP = 4;
    localparam int CB_SYNC = 5;

    typedef enum logic [0:0] {
        FR_HUNT = 1'b0,
        FR_LOCK = 1'b1
    } fr_state_t;
endpackage

// File: rtl/nrzi_decode.sv
module nrzi_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    assign dout = en ? (din ^ prev_q) : din;
endmodule

// File: rtl/self_sync_descrambler.sv
module self_sync_descrambler #(
    parameter int TAP_NEAR = 4,
    parameter int TAP_FAR  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    logic [TAP_FAR-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[TAP_FAR-2:0], din};
    end

    assign dout = en ? (din ^ hist_q[TAP_NEAR-1] ^ hist_q[TAP_FAR-1]) : din;
endmodule

// File: rtl/trs_word_framer.sv
module trs_word_framer
    import sdi_rx_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int CLIP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              sync_en,
    input  logic              clip_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              trs_found,
    output logic              aligned
);
    localparam int WIN_W = 3 * WORD_W;
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [WIN_W-1:0] TRS_PAT = {{(2*WORD_W){1'b0}}, {WORD_W{1'b1}}};

    logic [WIN_W-1:0]  win_q, win_nx;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        trs_left_q;
    fr_state_t         st_q, st_d;
    logic              hit, at_edge, is_trs;
    logic [WORD_W-1:0] oldest, shaped;

    assign win_nx  = {bit_in, win_q[WIN_W-1:1]};
    assign hit     = sync_en && (win_nx == TRS_PAT);
    assign at_edge = hit || (cnt_q == CNT_LAST);
    assign is_trs  = hit || (at_edge && (trs_left_q != 2'd0));
    assign oldest  = win_nx[WORD_W-1:0];
    assign shaped  = (clip_en && is_trs)
                   ? {oldest[WORD_W-1:CLIP_BITS], {CLIP_BITS{1'b0}}}
                   : oldest;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_HUNT: if (hit) st_d = FR_LOCK;
            FR_LOCK: st_d = FR_LOCK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_HUNT;
        else        st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            cnt_q      <= '0;
            trs_left_q <= 2'd0;
            word_out   <= '0;
            word_stb   <= 1'b0;
            trs_found  <= 1'b0;
        end else begin
            win_q     <= win_nx;
            word_stb  <= at_edge;
            trs_found <= hit;
            if (at_edge) begin
                cnt_q    <= '0;
                word_out <= shaped;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (hit)
                trs_left_q <= 2'd2;
            else if (at_edge && (trs_left_q != 2'd0))
                trs_left_q <= trs_left_q - 2'd1;
        end
    end

    assign aligned = (st_q == FR_LOCK);

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> (!word_stb || trs_found));
    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
    // R4
    trs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trs_found |-> (word_stb && aligned));
    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |=> aligned);
    // R5
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trs_found |-> $past(sync_en));
    // R6
    clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trs_found && $past(clip_en)) |-> (word_out[CLIP_BITS-1:0] == '0));
endmodule

// File: rtl/sdi_descrambler_aligner.sv
module sdi_descrambler_aligner
    import sdi_rx_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int TAP_NEAR  = 4,
    parameter int TAP_FAR   = 9,
    parameter int CLIP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] word_out,
    output logic              word_stb,
    output logic              trs_found,
    output logic              word_aligned
);
    logic nrz_bit, plain_bit;

    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= CTRL_RST;
        else if (cfg_we) ctrl_q <= cfg_wdata;
    end

    nrzi_decode u_nrzi (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl_q[CB_NRZI]),
        .din  (ser_bit),
        .dout (nrz_bit)
    );

    self_sync_descrambler #(
        .TAP_NEAR(TAP_NEAR),
        .TAP_FAR (TAP_FAR)
    ) u_dscr (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ctrl_q[CB_DSCR]),
        .din  (nrz_bit),
        .dout (plain_bit)
    );

    trs_word_framer #(
        .WORD_W   (WORD_W),
        .CLIP_BITS(CLIP_BITS)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (plain_bit),
        .sync_en  (ctrl_q[CB_SYNC]),
        .clip_en  (ctrl_q[CB_CLIP]),
        .word_out (word_out),
        .word_stb (word_stb),
        .trs_found(trs_found),
        .aligned  (word_aligned)
    );

    // R1
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ctrl_q == $past(cfg_wdata)));
endmodule

// File: tb/test_sdi_descrambler_aligner.sv
module test_sdi_descrambler_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] ctrl_q;
    logic [9:0] word_out;
    logic       word_stb, trs_found, word_aligned;

    always #5 clk = ~clk;

    sdi_descrambler_aligner i_sdi_descrambler_aligner (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .word_out(word_out),
        .word_stb(word_stb), .trs_found(trs_found), .word_aligned(word_aligned)
    );

    typedef struct { logic [9:0] w; bit trs; } exp_t;
    exp_t q[$];

    int   n_chk = 0, n_bad = 0;
    int   cyc = 0, last_stb = 0, trs_seen = 0;
    bit   have_stb = 0, done = 0;
    bit   use_nrzi, use_dscr, use_clip;
    logic enc_np;
    logic [8:0] enc_h;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // encoder mirrors R3 then R2 in reverse
    task automatic send_bit(input bit d);
        logic x, n;
        x = use_dscr ? (d ^ enc_h[3] ^ enc_h[8]) : d;
        enc_h = {enc_h[7:0], x};
        n = use_nrzi ? (x ^ enc_np) : x;
        enc_np = n;
        @(negedge clk) ser_bit = n;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) send_bit(w[i]);
    endtask

    task automatic send_payload(input logic [9:0] w);
        exp_t e;
        e.w = w; e.trs = 0;
        q.push_back(e);
        send_word(w);
    endtask

    task automatic send_trs();
        exp_t e;
        e.w = use_clip ? 10'h3FC : 10'h3FF; e.trs = 1;
        q.push_back(e);
        e.w = 10'h000; e.trs = 0;
        q.push_back(e);
        q.push_back(e);
        send_word(10'h3FF);
        send_word(10'h000);
        send_word(10'h000);
    endtask

    task automatic do_reset(input logic [7:0] cfg);
        @(negedge clk);
        rst_n = 0; ser_bit = 0; cfg_we = 0;
        enc_np = 0; enc_h = '0;
        q.delete(); trs_seen = 0; have_stb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(ctrl_q == 8'h36, "R1 reset ctrl", ctrl_q, 8'h36);
        chk(!word_stb && !trs_found, "R1 reset strobes", {word_stb, trs_found}, 0);
        chk(!word_aligned, "R8 reset aligned", word_aligned, 0);
        if (cfg != 8'h36) begin
            cfg_we = 1; cfg_wdata = cfg;
            @(negedge clk);
            cfg_we = 0;
            chk(ctrl_q == cfg, "R1 write", ctrl_q, cfg);
        end
        use_dscr = cfg[1]; use_nrzi = cfg[2]; use_clip = cfg[4];
    endtask

    task automatic finish_scn(input string tag);
        for (int i = 0; i < 40; i++) send_bit(1'b0);
        chk(q.size() == 0, tag, q.size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && word_stb) begin
            if (trs_found) trs_seen++;
            if (have_stb && !trs_found)
                chk(cyc - last_stb == 10, "R7 strobe spacing", cyc - last_stb, 10);
            have_stb = 1;
            last_stb = cyc;
            chk(word_aligned == (trs_seen > 0), "R8 aligned flag", word_aligned, trs_seen > 0);
            if (word_aligned && q.size() > 0) begin
                if (!(q[0].trs && !trs_found)) begin
                    exp_t e;
                    e = q.pop_front();
                    chk(word_out == e.w && trs_found == e.trs,
                        e.trs ? "R4/R6 trs word" : "R2/R3/R4 word",
                        {trs_found, word_out}, {e.trs, e.w});
                end
            end
        end
    end

    initial begin
        // all enables: offset, lock, payload, realign
        do_reset(8'h36);
        send_bit(1); send_bit(0); send_bit(1);
        send_word(10'h155); send_word(10'h0F0);
        send_trs();
        send_payload(10'h155); send_payload(10'h2AA); send_payload(10'h0F0);
        send_payload(10'h123); send_payload(10'h301); send_payload(10'h04C);
        for (int i = 0; i < 7; i++) send_bit(i[0]);
        send_trs();
        send_payload(10'h0AB); send_payload(10'h2C1); send_payload(10'h111);
        finish_scn("R4 realign drained");

        // clip off
        do_reset(8'h26);
        for (int i = 0; i < 4; i++) send_bit(1);
        send_trs();
        send_payload(10'h1A5); send_payload(10'h05A); send_payload(10'h2D2);
        finish_scn("R6 clip off drained");

        // descramble off
        do_reset(8'h34);
        send_bit(0); send_bit(1);
        send_trs();
        send_payload(10'h2AA); send_payload(10'h131); send_payload(10'h0C3);
        finish_scn("R3 bypass drained");

        // NRZI off
        do_reset(8'h32);
        for (int i = 0; i < 6; i++) send_bit(0);
        send_trs();
        send_payload(10'h099); send_payload(10'h252); send_payload(10'h10E);
        finish_scn("R2 bypass drained");

        // sync detect off
        do_reset(8'h16);
        send_bit(1); send_bit(1); send_bit(0);
        send_word(10'h3FF); send_word(10'h000); send_word(10'h000);
        send_word(10'h155);
        for (int i = 0; i < 40; i++) send_bit(0);
        chk(trs_seen == 0, "R5 no trs when disabled", trs_seen, 0);
        chk(!word_aligned, "R5/R8 stays unaligned", word_aligned, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule